// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block turns a 32-bit parent-bus address into a one-hot chip select for an external parallel bus with eight banks. Each bank has one window register. It holds an enable, a base aligned to 128 KiB, and a compare mask that states which upper address bits must equal the base. Software writes these registers through a simple register port. A request port presents a valid flag and an address. One cycle later the block returns the selected chip select, a hit flag and the offset of the address inside the bank.

A boot-swap strap is captured while reset is asserted. It decides which register slot holds the boot window after reset. It also decides how slots 0 and 1 are routed onto chip selects 0 and 1. When the strap is set, register slot 0 reads back as disabled, and software uses this to detect the swapped state.

Top module: `cs_window_decoder`

## Requirements
- R1: Window register slot i (0..7) sits at register offset 0x100 + 0x10*i and reads back what was last written there. Any other offset reads 0, and a write to it changes no slot.
- R2: In a window register, bit 0 is the enable, bits 31:17 are the base, and bits 15:1 are the compare mask. Bit 16 always reads 0, whatever was written.
- R3: An enabled slot matches an address when, for every mask bit k (1..15) that is 1, address bit k+16 equals register bit k+16. Address bits whose mask bit is 0 are not compared.
- R4: A slot whose enable bit is 0 never produces a chip select, whatever its base and mask hold.
- R5: When several slots match, only the lowest-numbered chip select among them is asserted. With bank 1 at 0x4200FE01 and bank 5 at 0x4800FF01, address 0x43F00000 gives chip select 1 with offset 0x01F00000, and address 0x48200000 gives chip select 5 with offset 0x00200000.
- R6: When no enabled slot matches, hit_o is 0 and cs_o is all zeros.
- R7: On a hit, offset_o is the address with the winning slot's compared bits (31:17) cleared; bits 16:0 pass through unchanged. On a miss, offset_o is 0.
- R8: Decode results appear on the clock edge after req_valid_i is sampled high, and valid_o marks them. In a cycle after req_valid_i was low, valid_o, hit_o and cs_o are 0.
- R9: After reset with the strap low, slot 0 holds the boot window 0x0000FC01, which covers 0x00000000 to 0x03FFFFFF, and every other slot holds 0. Slot i then drives chip select i.
- R10: After reset with the strap high, slot 0 reads 0 and slot 1 holds the boot window. Slot 1 drives chip select 0 and slot 0 drives chip select 1. Slots 2 to 7 are routed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_swap_i | input | 1 | Boot-swap strap, captured while in reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| req_valid_i | input | 1 | Decode request valid |
| req_addr_i | input | 32 | Parent-bus address to decode |
| valid_o | output | 1 | Decode result valid |
| hit_o | output | 1 | Some enabled window matched |
| cs_o | output | 8 | One-hot chip select |
| offset_o | output | 32 | Address offset within the selected bank |

## Verification
The assertions take it for granted that the strap is stable while reset is released, and that req_addr_i is stable while req_valid_i is high. The stimulus changes every input on the falling clock edge, and it changes the strap only with reset held low. Windows are programmed with contiguous masks of the power-of-two kind. Overlapping windows are set up on purpose only to exercise the priority order.

// File: rtl/cswin_pkg.sv
package cswin_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned GRAN_LG = 17;  // 128 KiB granularity
  localparam int unsigned MASK_W  = ADDR_W - GRAN_LG;
  typedef logic [ADDR_W-1:0] win_t;
  // bit 16 is reserved and never stored
  localparam win_t WR_KEEP = ~(win_t'(1) << (GRAN_LG - 1));
endpackage

// File: rtl/cswin_regs.sv
module cswin_regs
  import cswin_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 8,
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned REG_BASE   = 'h100,
  parameter int unsigned REG_STRIDE = 'h10,
  parameter win_t        BOOT_WIN   = 32'h0000_FC01
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 boot_swap_i,
  input  logic                 we_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  win_t                 wdata_i,
  output win_t                 rdata_o,
  output win_t                 slot_o [NUM_BANKS],
  output logic                 swap_o
);
  localparam int unsigned STRIDE_LG = $clog2(REG_STRIDE);
  localparam int unsigned IDX_W     = $clog2(NUM_BANKS);

  logic [REG_AW-1:0] off;
  logic [REG_AW-1:0] slot_num;
  logic              sel_ok;
  logic [IDX_W-1:0]  sel_idx;
  win_t              slot_q [NUM_BANKS];
  logic              swap_q;

  assign off      = addr_i - REG_AW'(REG_BASE);
  assign slot_num = off >> STRIDE_LG;
  assign sel_ok   = (addr_i >= REG_AW'(REG_BASE)) && (off[STRIDE_LG-1:0] == '0)
                    && (slot_num < REG_AW'(NUM_BANKS));
  assign sel_idx  = IDX_W'(slot_num);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swap_q <= boot_swap_i;
      for (int i = 0; i < NUM_BANKS; i++)
        slot_q[i] <= ((i == 0 && !boot_swap_i) || (i == 1 && boot_swap_i)) ? BOOT_WIN : '0;
    end else if (we_i && sel_ok) begin
      slot_q[sel_idx] <= wdata_i & WR_KEEP;
    end
  end

  assign rdata_o = sel_ok ? slot_q[sel_idx] : '0;
  assign swap_o  = swap_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_out
    assign slot_o[g] = slot_q[g];
  end
endmodule

// File: rtl/cswin_match.sv
module cswin_match
  import cswin_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  win_t                 addr_i,
  input  win_t                 slot_i [NUM_BANKS],
  input  logic                 swap_i,
  output logic [NUM_BANKS-1:0] match_o,   // indexed by chip select
  output win_t                 win_o [NUM_BANKS]
);
  logic [NUM_BANKS-1:0] slot_hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    logic [MASK_W-1:0] diff;
    assign diff        = addr_i[ADDR_W-1:GRAN_LG] ^ slot_i[g][ADDR_W-1:GRAN_LG];
    assign slot_hit[g] = slot_i[g][0] && ((diff & slot_i[g][GRAN_LG-2:1]) == '0);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_route
    if (g < 2) begin : g_sw
      assign match_o[g] = swap_i ? slot_hit[1-g] : slot_hit[g];
      assign win_o[g]   = swap_i ? slot_i[1-g]   : slot_i[g];
    end else begin : g_dir
      assign match_o[g] = slot_hit[g];
      assign win_o[g]   = slot_i[g];
    end
  end
endmodule

// File: rtl/cswin_select.sv
module cswin_select
  import cswin_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  win_t                 addr_i,
  input  logic [NUM_BANKS-1:0] match_i,
  input  win_t                 win_i [NUM_BANKS],
  output logic [NUM_BANKS-1:0] cs_o,
  output logic                 hit_o,
  output win_t                 offset_o
);
  logic [MASK_W-1:0] mask;

  always_comb begin
    cs_o  = '0;
    hit_o = 1'b0;
    mask  = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (match_i[i] && !hit_o) begin
        cs_o[i] = 1'b1;
        hit_o   = 1'b1;
        mask    = win_i[i][GRAN_LG-2:1];
      end
    end
  end

  assign offset_o = hit_o ? {addr_i[ADDR_W-1:GRAN_LG] & ~mask, addr_i[GRAN_LG-1:0]} : '0;
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswin_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 8,
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned REG_BASE   = 'h100,
  parameter int unsigned REG_STRIDE = 'h10,
  parameter logic [31:0] BOOT_WIN   = 32'h0000_FC01
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 boot_swap_i,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic                 req_valid_i,
  input  logic [31:0]          req_addr_i,
  output logic                 valid_o,
  output logic                 hit_o,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic [31:0]          offset_o
);
  win_t                 slot [NUM_BANKS];
  win_t                 win  [NUM_BANKS];
  logic                 swap;
  logic [NUM_BANKS-1:0] match;
  logic [NUM_BANKS-1:0] cs_d;
  logic                 hit_d;
  win_t                 ofs_d;

  cswin_regs #(
    .NUM_BANKS(NUM_BANKS), .REG_AW(REG_AW), .REG_BASE(REG_BASE),
    .REG_STRIDE(REG_STRIDE), .BOOT_WIN(BOOT_WIN)
  ) u_regs (
    .clk_i, .rst_ni, .boot_swap_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .slot_o(slot), .swap_o(swap)
  );

  cswin_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .addr_i(req_addr_i), .slot_i(slot), .swap_i(swap), .match_o(match), .win_o(win)
  );

  cswin_select #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .addr_i(req_addr_i), .match_i(match), .win_i(win),
    .cs_o(cs_d), .hit_o(hit_d), .offset_o(ofs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      hit_o    <= 1'b0;
      cs_o     <= '0;
      offset_o <= '0;
    end else begin
      valid_o  <= req_valid_i;
      hit_o    <= req_valid_i & hit_d;
      cs_o     <= req_valid_i ? cs_d  : '0;
      offset_o <= req_valid_i ? ofs_d : '0;
    end
  end
endmodule

// File: rtl/cswin_checker.sv
module cswin_checker #(
  parameter int unsigned NUM_BANKS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [31:0]          reg_rdata_o,
  input logic                 req_valid_i,
  input logic [31:0]          req_addr_i,
  input logic                 valid_o,
  input logic                 hit_o,
  input logic [NUM_BANKS-1:0] cs_o,
  input logic [31:0]          offset_o
);
  AST_RD_BIT16_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[16] == 1'b0);  // R2
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));  // R5
  AST_HIT_MATCHES_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (cs_o != '0));  // R6
  AST_MISS_ZERO_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> offset_o == '0);  // R7
  AST_OFS_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!hit_o || offset_o[16:0] == $past(req_addr_i[16:0])));  // R7
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && !hit_o && cs_o == '0));  // R8
endmodule

bind cs_window_decoder cswin_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i, .rst_ni, .reg_rdata_o, .req_valid_i, .req_addr_i,
  .valid_o, .hit_o, .cs_o, .offset_o
);

// File: tb/tb_cs_window_decoder.sv
module tb_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        we = 1'b0;
  logic [11:0] raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rv = 1'b0;
  logic [31:0] ra = '0;
  logic        vo, hit;
  logic [7:0]  cs;
  logic [31:0] ofs;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cs_window_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_swap_i(strap),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .req_valid_i(rv), .req_addr_i(ra),
    .valid_o(vo), .hit_o(hit), .cs_o(cs), .offset_o(ofs)
  );

  // address, expected chip select, expected offset
  localparam logic [31:0] VA [8] = '{32'h43F0_0000, 32'h4820_0000, 32'h4900_0000, 32'h6000_0000,
                                     32'h0123_4567, 32'h4400_0000, 32'h4201_ABCD, 32'h41FF_FFFF};
  localparam logic [7:0]  VC [8] = '{8'h02, 8'h04, 8'h04, 8'h00, 8'h01, 8'h00, 8'h02, 8'h00};
  localparam logic [31:0] VO [8] = '{32'h01F0_0000, 32'h0020_0000, 32'h0100_0000, 32'h0,
                                     32'h0123_4567, 32'h0, 32'h0001_ABCD, 32'h0};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    raddr = a;
    #1 d = rdata;
  endtask

  task automatic dec(input logic [31:0] a);
    @(negedge clk);
    rv = 1'b1; ra = a;
    @(negedge clk);
    rv = 1'b0;
  endtask

  task automatic dec_chk(input string req, input logic [31:0] a,
                         input logic [7:0] ecs, input logic [31:0] eofs);
    dec(a);
    chk(req, {31'b0, vo}, 32'd1);
    chk(req, {24'b0, cs}, {24'b0, ecs});
    chk(req, {31'b0, hit}, {31'b0, (ecs != 8'h0)});
    chk(req, ofs, eofs);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset(1'b0);
    // R9 reset contents and idle outputs
    rd(12'h100, d); chk("R9 slot0", d, 32'h0000_FC01);
    for (int i = 1; i < 8; i++) begin
      rd(12'(12'h100 + 12'h10 * i), d); chk("R9 slotN", d, 32'h0);
    end
    chk("R8 idle valid", {31'b0, vo}, 32'd0);
    chk("R8 idle cs", {24'b0, cs}, 32'd0);

    // R1 map and ignored offsets
    wr(12'h110, 32'h4200_FE01);
    wr(12'h150, 32'h4800_FF01);
    wr(12'h120, 32'h4800_FE01);
    wr(12'h130, 32'h6000_F000);  // R4 disabled slot
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h110, d); chk("R1 slot1", d, 32'h4200_FE01);
    rd(12'h150, d); chk("R1 slot5", d, 32'h4800_FF01);
    rd(12'h104, d); chk("R1 gap", d, 32'h0);
    rd(12'h180, d); chk("R1 past end", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      if (i != 0 && i != 1 && i != 2 && i != 3 && i != 5) begin
        rd(12'(12'h100 + 12'h10 * i), d); chk("R1 untouched", d, 32'h0);
      end
    end

    // R2 bit 16 never stored
    wr(12'h170, 32'hFFFF_FFFF);
    rd(12'h170, d); chk("R2 bit16", d, 32'hFFFE_FFFF);
    wr(12'h170, 32'h0);

    // table: R3 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) dec_chk("R3/R4/R5/R6/R7 vector", VA[i], VC[i], VO[i]);

    // R5 example once the overlapping slot 2 is disabled
    wr(12'h120, 32'h4800_FE00);
    dec_chk("R5 bank5 example", 32'h4820_0000, 8'h20, 32'h0020_0000);
    dec_chk("R3 unmasked bit", 32'h4840_0000, 8'h20, 32'h0040_0000);
    dec_chk("R6 just past bank5", 32'h4900_0000, 8'h00, 32'h0);

    // R8 latency and idle
    @(negedge clk);
    rv = 1'b1; ra = 32'h43F0_0000;
    @(negedge clk);
    rv = 1'b0;
    chk("R8 after one edge", {24'b0, cs}, 32'h02);
    @(negedge clk);
    chk("R8 idle cs", {24'b0, cs}, 32'h0);
    chk("R8 idle valid", {31'b0, vo}, 32'h0);
    chk("R8 idle hit", {31'b0, hit}, 32'h0);

    // R10 swapped strap
    do_reset(1'b1);
    rd(12'h100, d); chk("R10 slot0 reads 0", d, 32'h0);
    rd(12'h110, d); chk("R10 slot1 boot", d, 32'h0000_FC01);
    dec_chk("R10 slot1 to cs0", 32'h0100_0000, 8'h01, 32'h0100_0000);
    wr(12'h100, 32'h4200_FE01);
    dec_chk("R10 slot0 to cs1", 32'h4300_0000, 8'h02, 32'h0100_0000);
    wr(12'h150, 32'h4800_FF01);
    dec_chk("R10 slot5 direct", 32'h4820_0000, 8'h20, 32'h0020_0000);

    // R9 strap low again restores routing
    do_reset(1'b0);
    rd(12'h110, d); chk("R9 slot1 cleared", d, 32'h0);
    dec_chk("R9 boot window cs0", 32'h03FF_FFFC, 8'h01, 32'h03FF_FFFC);
    dec_chk("R6 outside boot", 32'h0400_0000, 8'h00, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule